// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block gathers the level-sensitive interrupt pins (A to D) of every device on a PCI bus and folds them onto four shared interrupt request lines. The fold rotates the pin index by the device number, so devices in neighbouring slots spread their first pin across different shared lines. Each shared line is then steered to one of sixteen inputs of a legacy interrupt controller by a byte-wide routing register. A route value of sixteen or more switches that line off.

Pin level changes arrive as single-cycle events that carry a device number, a pin index and the new level. The block keeps the current level of each shared line. The routing registers are written and read through a byte-wide configuration port. All sixteen controller inputs are recomputed from the stored levels and routes, so the outputs follow every level change or route change one clock edge later. Several shared lines may land on the same controller input, and that input then shows the OR of their levels.

Top module: `pci_irq_router`

## Requirements
- R1: A pin event on device number D and pin index P (A=0, B=1, C=2, D=3) sets the level of shared line (P + D + 3) mod 4, which is the same as (P + D - 1) mod 4. The new level is stored at the clock edge that samples the event.
- R2: The routing bytes for shared lines 0, 1, 2 and 3 sit at configuration offsets 0x60, 0x61, 0x62 and 0x63. A write to one of these offsets stores the byte. `cfgRdData` returns the stored byte for the offset on `cfgAddr`.
- R3: A routing byte with a value of 16 or more disables its shared line. A disabled line drives none of the sixteen outputs. A routing byte of 0 to 15 drives output bit number equal to that value.
- R4: Each output bit is the OR of the levels of every enabled shared line routed to it.
- R5: With `ALT_PROFILE`=0, reset loads 0x80 into all four routing bytes. With `ALT_PROFILE`=1, reset loads 10, 10, 11 and 11 into the routing bytes of lines 0 to 3.
- R6: Reset clears the stored levels of all four shared lines to 0.
- R7: The outputs reflect the stored levels and routes of the current cycle. An output whose last source drops its level, or is routed away, is low one clock edge after the event or write.
- R8: A configuration write to any offset outside 0x60 to 0x63 changes no routing byte and no output. A read at such an offset returns 0.
- R9: A shared line that receives no event keeps its last stored level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Single-cycle strobe for a pin level event |
| evtDev | input | DEV_W | Device number of the event |
| evtPin | input | 2 | Pin index of the event, A=0 to D=3 |
| evtLevel | input | 1 | New level of the pin |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration offset, used for both write and read |
| cfgWrData | input | 8 | Configuration write byte |
| cfgRdData | output | 8 | Routing byte at `cfgAddr`, or 0 outside the routing window |
| irqOut | output | NUM_IRQ | Level-sensitive requests to the interrupt controller |

## Verification
The hardest situation to reach from the ports is a single controller input fed by several shared lines at once, where only the last remaining source may release the output. To reach it, the stimulus routes all four lines to one input, raises a pin on each line through devices chosen so that the rotation hits every line, and then lowers the levels one at a time. After that it moves the routes away one by one and checks that the output drops only after the last one leaves. A full sweep of every device number against every pin, with distinct routes per line, pins the rotation down arithmetically. A second sweep runs one route byte through values on both sides of sixteen.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int LINES  = 4;
  localparam int LINE_W = $clog2(LINES);

  typedef struct packed {
    logic              levelWe;
    logic [LINE_W-1:0] levelIdx;
    logic              levelVal;
    logic              routeWe;
    logic [LINE_W-1:0] routeIdx;
    logic [7:0]        routeVal;
    logic              rdHit;
    logic [LINE_W-1:0] rdIdx;
  } pirq_strobe_t;
endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int         DEV_W      = 5,
  parameter logic [7:0] ROUTE_BASE = 8'h60
) (
  input  logic             evtValid,
  input  logic [DEV_W-1:0] evtDev,
  input  logic [1:0]       evtPin,
  input  logic             evtLevel,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgAddr,
  input  logic [7:0]       cfgWrData,
  output pirq_strobe_t     strb
);
  localparam logic [7:0] ROUTE_LAST = ROUTE_BASE + 8'(LINES - 1);

  logic [7:0] offs;
  logic       inWindow;

  assign offs     = cfgAddr - ROUTE_BASE;
  assign inWindow = (cfgAddr >= ROUTE_BASE) && (cfgAddr <= ROUTE_LAST);

  always_comb begin
    strb          = '0;
    // rotate the pin by slot: (pin + dev - 1) mod LINES
    strb.levelWe  = evtValid;
    strb.levelIdx = LINE_W'(evtPin) + LINE_W'(evtDev) - LINE_W'(1);
    strb.levelVal = evtLevel;
    strb.routeWe  = cfgWrEn && inWindow;
    strb.routeIdx = offs[LINE_W-1:0];
    strb.routeVal = cfgWrData;
    strb.rdHit    = inWindow;
    strb.rdIdx    = offs[LINE_W-1:0];
  end
endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int NUM_IRQ     = 16,
  parameter bit ALT_PROFILE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pirq_strobe_t       strb,
  output logic [7:0]         cfgRdData,
  output logic [NUM_IRQ-1:0] irqOut
);
  logic [LINES-1:0]      lineLevel;
  logic [LINES-1:0][7:0] routeReg;

  function automatic logic [7:0] resetRoute(int idx);
    if (ALT_PROFILE) return (idx < 2) ? 8'd10 : 8'd11;
    return 8'h80;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineLevel <= '0;
      for (int l = 0; l < LINES; l++) routeReg[l] <= resetRoute(l);
    end else begin
      if (strb.levelWe) lineLevel[strb.levelIdx] <= strb.levelVal;
      if (strb.routeWe) routeReg[strb.routeIdx]  <= strb.routeVal;
    end
  end

  assign cfgRdData = strb.rdHit ? routeReg[strb.rdIdx] : 8'h00;

  // Each controller input ORs the enabled lines whose route selects it;
  // a route of NUM_IRQ or above never equals an output index.
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    always_comb begin
      irqOut[i] = 1'b0;
      for (int l = 0; l < LINES; l++)
        if ((routeReg[l] == 8'(i)) && lineLevel[l]) irqOut[i] = 1'b1;
    end
  end

  p_level_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.levelWe |=> lineLevel[$past(strb.levelIdx)] == $past(strb.levelVal));
  p_route_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.routeWe |=> routeReg[$past(strb.routeIdx)] == $past(strb.routeVal));
  p_or_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irqOut) <= $countones(lineLevel));
  p_route_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.routeWe |=> $stable(routeReg));
  p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.levelWe |=> $stable(lineLevel));
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pirq_pkg::*;
#(
  parameter int         DEV_W       = 5,
  parameter int         NUM_IRQ     = 16,
  parameter logic [7:0] ROUTE_BASE  = 8'h60,
  parameter bit         ALT_PROFILE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evtValid,
  input  logic [DEV_W-1:0]   evtDev,
  input  logic [1:0]         evtPin,
  input  logic               evtLevel,
  input  logic               cfgWrEn,
  input  logic [7:0]         cfgAddr,
  input  logic [7:0]         cfgWrData,
  output logic [7:0]         cfgRdData,
  output logic [NUM_IRQ-1:0] irqOut
);
  pirq_strobe_t strb;

  pirq_ctrl #(.DEV_W(DEV_W), .ROUTE_BASE(ROUTE_BASE)) u_ctrl (
    .evtValid (evtValid),
    .evtDev   (evtDev),
    .evtPin   (evtPin),
    .evtLevel (evtLevel),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .strb     (strb)
  );

  pirq_datapath #(.NUM_IRQ(NUM_IRQ), .ALT_PROFILE(ALT_PROFILE)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .cfgRdData(cfgRdData),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/pci_irq_router_bench.sv
module pci_irq_router_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evtValid = 1'b0;
  logic [4:0]  evtDev = '0;
  logic [1:0]  evtPin = '0;
  logic        evtLevel = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData, altRd;
  logic [15:0] irqOut, altIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic       expLevel [4];
  logic [7:0] expRoute [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_irq_router u_pci_irq_router (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtDev(evtDev),
    .evtPin(evtPin), .evtLevel(evtLevel), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .irqOut(irqOut));

  pci_irq_router #(.ALT_PROFILE(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtDev(evtDev),
    .evtPin(evtPin), .evtLevel(evtLevel), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgRdData(altRd),
    .irqOut(altIrq));

  function automatic logic [15:0] modelIrq();
    logic [15:0] v = '0;
    for (int l = 0; l < 4; l++)
      if (expLevel[l] && expRoute[l] < 8'd16) v[expRoute[l][3:0]] = 1'b1;
    return v;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pinEvent(int dev, int pin, logic lvl);
    @(negedge clk);
    evtValid = 1'b1; evtDev = 5'(dev); evtPin = 2'(pin); evtLevel = lvl;
    expLevel[(pin + dev + 3) % 4] = lvl;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic cfgWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    if (a >= 8'h60 && a <= 8'h63) expRoute[a - 8'h60] = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int l = 0; l < 4; l++) begin expLevel[l] = 1'b0; expRoute[l] = 8'h80; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R5 / R6: reset state
    check("R6 irq after reset", irqOut, 16'h0);
    for (int l = 0; l < 4; l++) begin
      cfgAddr = 8'(8'h60 + l); #1;
      check("R5 default route", 16'(cfgRdData), 16'h0080);
      check("R5 alt route", 16'(altRd), (l < 2) ? 16'd10 : 16'd11);
    end

    // R1 / R7: sweep every device against every pin, line l routed to l+4
    for (int l = 0; l < 4; l++) cfgWrite(8'(8'h60 + l), 8'(l + 4));
    for (int l = 0; l < 4; l++) begin
      cfgAddr = 8'(8'h60 + l); #1;
      check("R2 route readback", 16'(cfgRdData), 16'(l + 4));
    end
    for (int d = 0; d < 32; d++)
      for (int p = 0; p < 4; p++) begin
        pinEvent(d, p, 1'b1);
        check("R1 swizzle raise", irqOut, 16'h1 << (((p + d + 3) % 4) + 4));
        pinEvent(d, p, 1'b0);
        check("R7 drop next cycle", irqOut, 16'h0);
      end

    // R9: lines without events keep their level
    pinEvent(1, 0, 1'b1);
    pinEvent(1, 2, 1'b1);
    pinEvent(1, 1, 1'b0);
    check("R9 hold lines 0 and 2", irqOut, 16'h0050);
    pinEvent(1, 0, 1'b0);
    pinEvent(1, 2, 1'b0);

    // R3: route byte on both sides of 16, line 0 high
    pinEvent(1, 0, 1'b1);
    for (int v = 0; v < 40; v++) begin
      cfgWrite(8'h60, 8'(v));
      check("R3 route value", irqOut, modelIrq());
    end
    cfgWrite(8'h60, 8'hFF);
    check("R3 route 0xFF off", irqOut, 16'h0);

    // R4: all lines onto input 7, release one at a time
    for (int l = 0; l < 4; l++) cfgWrite(8'(8'h60 + l), 8'd7);
    for (int p = 0; p < 4; p++) pinEvent(1, p, 1'b1);
    check("R4 all on input 7", irqOut, 16'h0080);
    for (int p = 0; p < 4; p++) begin
      pinEvent(1, p, 1'b0);
      check("R4 partial release", irqOut, modelIrq());
    end
    for (int p = 0; p < 4; p++) pinEvent(1, p, 1'b1);
    for (int l = 0; l < 4; l++) begin
      cfgWrite(8'(8'h60 + l), 8'h90);
      check("R7 route away", irqOut, (l < 3) ? 16'h0080 : 16'h0);
    end

    // R8: writes outside the routing window are ignored
    for (int l = 0; l < 4; l++) cfgWrite(8'(8'h60 + l), 8'(l + 1));
    check("R4 distinct routes", irqOut, 16'h001E);
    for (int a = 0; a < 256; a++) begin
      if (a >= 8'h60 && a <= 8'h63) continue;
      cfgWrite(8'(a), 8'h03);
      #1;
      check("R8 read outside window", 16'(cfgRdData), 16'h0);
      check("R8 irq unchanged", irqOut, 16'h001E);
    end
    for (int l = 0; l < 4; l++) begin
      cfgAddr = 8'(8'h60 + l); #1;
      check("R8 routes unchanged", 16'(cfgRdData), 16'(l + 1));
    end

    // R6: reset clears levels, seen once routes are enabled again
    doReset();
    for (int l = 0; l < 4; l++) cfgWrite(8'(8'h60 + l), 8'(l + 1));
    check("R6 levels cleared", irqOut, 16'h0);
    check("R6 model agrees", modelIrq(), 16'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule